// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block keeps the tag and state side of a set-associative cache and holds no line data. A caller issues one command per cycle on a valid/ready request port. Each command carries a line-aligned address, an opcode and a few side fields: request kind, touch flag, lock context and new permission. One cycle later a response is registered. It reports hit, way, access grant, availability, lock match, an address result and an error flag.

Each way records whether it holds an entry, the full line address, a three-bit permission state and a lock-owner context. A line is present only when its address matches and its permission is not "not present". A raw lookup can also match on the address alone and ignore the permission. Replacement uses per-set age counters that form a least-recently-used order. Illegal commands are rejected with an error pulse and leave all state untouched.

The sizes are parameters. There are `SIZE_BYTES / ASSOC / LINE_BYTES` sets, and at least two are required. The set index is `log2(sets)` address bits starting at `START_BIT`.

Top module: `tagdir`

## Requirements
- R1: During reset `req_ready_o` and `rsp_valid_o` are 0. From the first clock after reset `req_ready_o` is 1, and every way starts empty, so any lookup misses. While `rsp_valid_o` is 0 all other response outputs are 0.
- R2: The set is chosen by address bits `[START_BIT +: log2(sets)]`. Addresses that differ in those bits use separate sets, and each set keeps its own ways.
- R3: Opcode 0 (lookup) hits only when a way holds the exact address with permission not 0. It returns the lowest such way. Opcode 1 (raw lookup) hits on an address match whatever the permission. Permission codes are: 0 not present, 1 invalid, 2 read-only, 3 read-write, 4 busy.
- R4: Opcode 2 (access check) grants when the present line is read-write. It also grants when the line is read-only and the kind is load (0) or fetch (1). A store (kind 2) to a read-only line is denied, and every other case is denied. `rsp_hit_o` still shows presence.
- R5: A hit on lookup or access check makes that way most recently used. A raw lookup changes no recency.
- R6: Opcode 3 (availability) reports 1 when a way already holds the address, or when some way is empty or has permission 0.
- R7: Opcode 4 (allocate) takes the lowest empty or permission-0 way and returns it. It sets permission 1 and clears the owner to all-ones. It updates recency only when `req_touch_i` is 1. Opcode 5 (deallocate) empties the way of a present line.
- R8: Opcode 6 (victim probe) returns the least recently used way and the address it holds. Right after reset the victim of every set is way `ASSOC-1`.
- R9: Opcode 7 stores `req_ctx_i` as the owner of a present line, and opcode 8 resets the owner to all-ones. Opcode 9 returns `rsp_locked_o` = 1 only when the stored owner equals `req_ctx_i`.
- R10: Opcode 11 reads the address of flat entry `req_addr_i`, which maps to set = index / ASSOC and way = index mod ASSOC. It returns 0 when that entry is empty or has permission 0 or 1.
- R11: Opcode 10 writes `req_perm_i` into a present line. Permission 0 makes the line no longer present.
- R12: These commands raise `rsp_err_o` for their single response and change no state: allocate of a present address or into a full set; deallocate, lock, unlock, lock query or permission write on a non-present address; probe of an available set; a permission code above 4; a flat index of `sets*ASSOC` or more; opcodes 12 to 15.
- R13: Each accepted request yields exactly one response with `rsp_valid_o` high in the following cycle, and nothing else does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 4 | Opcode |
| req_addr_i | input | ADDR_W | Line address, or flat index for opcode 11 |
| req_kind_i | input | 2 | Request kind: load 0, fetch 1, store 2 |
| req_touch_i | input | 1 | Allocate updates recency |
| req_ctx_i | input | CTX_W | Lock context |
| req_perm_i | input | 3 | New permission for opcode 10 |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Command was illegal |
| rsp_hit_o | output | 1 | Lookup or access hit |
| rsp_way_o | output | log2(ASSOC) | Hit, allocated or victim way |
| rsp_grant_o | output | 1 | Access granted |
| rsp_avail_o | output | 1 | Set availability |
| rsp_locked_o | output | 1 | Owner equals queried context |
| rsp_addr_o | output | ADDR_W | Victim or read-back address |

## Verification
The assertions assume line-aligned addresses and a caller that offers requests only through the valid/ready handshake. They also assume at most one way of a set ever holds a present copy of an address. The stimulus keeps to this by using a small pool of line-aligned addresses spread over all sets. Allocation of a present address is only ever tried as an expected error. A reference model in the bench, fed the same commands, predicts every response. It covers the illegal cases, the reuse of permission-0 ways and out-of-range flat indices.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [3:0] {
    OP_LOOKUP  = 4'd0,
    OP_PEEK    = 4'd1,
    OP_ACCESS  = 4'd2,
    OP_AVAIL   = 4'd3,
    OP_ALLOC   = 4'd4,
    OP_FREE    = 4'd5,
    OP_PROBE   = 4'd6,
    OP_LOCK    = 4'd7,
    OP_UNLOCK  = 4'd8,
    OP_LOCKED  = 4'd9,
    OP_SETPERM = 4'd10,
    OP_READIDX = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    PERM_NP   = 3'd0,
    PERM_INV  = 3'd1,
    PERM_RO   = 3'd2,
    PERM_RW   = 3'd3,
    PERM_BUSY = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2
  } kind_e;
endpackage

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int ADDR_W = 32,
  parameter int ASSOC  = 4,
  parameter int WAY_W  = 2
) (
  input  logic [ASSOC-1:0]             vld_i,
  input  logic [ASSOC-1:0][ADDR_W-1:0] addr_i,
  input  logic [ASSOC-1:0][2:0]        perm_i,
  input  logic [ADDR_W-1:0]            key_i,
  output logic                         match_any_o,
  output logic [WAY_W-1:0]             match_way_o,
  output logic                         pres_any_o,
  output logic [WAY_W-1:0]             pres_way_o,
  output logic                         free_any_o,
  output logic [WAY_W-1:0]             free_way_o
);
  logic [ASSOC-1:0] match_v, pres_v, free_v;

  for (genvar w = 0; w < ASSOC; w++) begin : g_way
    assign match_v[w] = vld_i[w] && (addr_i[w] == key_i);
    assign pres_v[w]  = match_v[w] && (perm_i[w] != 3'd0);
    assign free_v[w]  = !vld_i[w] || (perm_i[w] == 3'd0);
  end

  assign match_any_o = |match_v;
  assign pres_any_o  = |pres_v;
  assign free_any_o  = |free_v;

  // lowest way wins
  always_comb begin
    match_way_o = '0;
    pres_way_o  = '0;
    free_way_o  = '0;
    for (int w = ASSOC - 1; w >= 0; w--) begin
      if (match_v[w]) match_way_o = WAY_W'(w);
      if (pres_v[w])  pres_way_o  = WAY_W'(w);
      if (free_v[w])  free_way_o  = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS  = 4,
  parameter int ASSOC = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(ASSOC - 1);

  // per set the ages form a permutation of 0..ASSOC-1
  logic [SETS-1:0][ASSOC-1:0][WAY_W-1:0] age_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAY_W-1:0] ref_age;
    assign ref_age = age_q[s][touch_way_i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < ASSOC; w++) age_q[s][w] <= WAY_W'(w);
      end else if (touch_i && (touch_set_i == IDX_W'(s))) begin
        for (int w = 0; w < ASSOC; w++) begin
          if (WAY_W'(w) == touch_way_i)   age_q[s][w] <= '0;
          else if (age_q[s][w] < ref_age) age_q[s][w] <= age_q[s][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < ASSOC; w++)
      if (age_q[query_set_i][w] == OLDEST) victim_o = WAY_W'(w);
  end
endmodule

// File: rtl/tagdir.sv
module tagdir
  import tagdir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ASSOC      = 4,
  parameter int SIZE_BYTES = 1024,
  parameter int START_BIT  = $clog2(LINE_BYTES),
  parameter int CTX_W      = 4,
  localparam int SETS      = SIZE_BYTES / ASSOC / LINE_BYTES,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WAY_W     = (ASSOC > 1) ? $clog2(ASSOC) : 1,
  localparam int ENTRIES   = SETS * ASSOC,
  localparam int FLAT_W    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_touch_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic [2:0]        req_perm_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic              rsp_hit_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic              rsp_grant_o,
  output logic              rsp_avail_o,
  output logic              rsp_locked_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0][2:0]        ent_perm;
  logic [ENTRIES-1:0][CTX_W-1:0]  ent_own;

  logic             ready_q;
  logic             fire;
  logic [IDX_W-1:0] req_set;

  function automatic logic [FLAT_W-1:0] flat(input logic [IDX_W-1:0] s,
                                             input logic [WAY_W-1:0] w);
    return FLAT_W'(int'(s) * ASSOC + int'(w));
  endfunction

  assign req_ready_o = ready_q;
  assign fire        = req_valid_i && ready_q;
  assign req_set     = req_addr_i[START_BIT +: IDX_W];

  // ways of the addressed set
  logic [ASSOC-1:0]             set_vld;
  logic [ASSOC-1:0][ADDR_W-1:0] set_addr;
  logic [ASSOC-1:0][2:0]        set_perm;

  always_comb begin
    for (int w = 0; w < ASSOC; w++) begin
      set_vld[w]  = ent_vld[flat(req_set, WAY_W'(w))];
      set_addr[w] = ent_addr[flat(req_set, WAY_W'(w))];
      set_perm[w] = ent_perm[flat(req_set, WAY_W'(w))];
    end
  end

  logic             match_any, pres_any, free_any;
  logic [WAY_W-1:0] match_way, pres_way, free_way, victim_way;

  tagdir_match #(.ADDR_W(ADDR_W), .ASSOC(ASSOC), .WAY_W(WAY_W)) u_match (
    .vld_i       (set_vld),
    .addr_i      (set_addr),
    .perm_i      (set_perm),
    .key_i       (req_addr_i),
    .match_any_o (match_any),
    .match_way_o (match_way),
    .pres_any_o  (pres_any),
    .pres_way_o  (pres_way),
    .free_any_o  (free_any),
    .free_way_o  (free_way)
  );

  logic             touch_d;
  logic [WAY_W-1:0] touch_way_d;

  tagdir_lru #(.SETS(SETS), .ASSOC(ASSOC), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (fire && touch_d),
    .touch_set_i (req_set),
    .touch_way_i (touch_way_d),
    .query_set_i (req_set),
    .victim_o    (victim_way)
  );

  // command decode
  logic              err_d, hit_d, grant_d, avail_d, locked_d, wr_d;
  logic [WAY_W-1:0]  way_d;
  logic [ADDR_W-1:0] addr_d;
  logic [FLAT_W-1:0] tgt, ridx;
  logic              n_vld;
  logic [ADDR_W-1:0] n_addr;
  logic [2:0]        n_perm;
  logic [CTX_W-1:0]  n_own;
  logic [2:0]        hit_perm;
  logic              avail;

  assign avail    = match_any || free_any;
  assign hit_perm = ent_perm[flat(req_set, pres_way)];
  assign ridx     = req_addr_i[FLAT_W-1:0];

  always_comb begin
    err_d       = 1'b0;
    hit_d       = 1'b0;
    grant_d     = 1'b0;
    avail_d     = 1'b0;
    locked_d    = 1'b0;
    way_d       = '0;
    addr_d      = '0;
    touch_d     = 1'b0;
    touch_way_d = pres_way;
    wr_d        = 1'b0;
    tgt = (req_op_i == OP_ALLOC) ? flat(req_set, free_way) : flat(req_set, pres_way);
    n_vld  = ent_vld[tgt];
    n_addr = ent_addr[tgt];
    n_perm = ent_perm[tgt];
    n_own  = ent_own[tgt];
    case (req_op_i)
      OP_LOOKUP: begin
        hit_d   = pres_any;
        way_d   = pres_any ? pres_way : '0;
        touch_d = pres_any;
      end
      OP_PEEK: begin
        hit_d = match_any;
        way_d = match_any ? match_way : '0;
      end
      OP_ACCESS: begin
        hit_d   = pres_any;
        way_d   = pres_any ? pres_way : '0;
        touch_d = pres_any;
        grant_d = pres_any && ((hit_perm == PERM_RW) ||
                  ((hit_perm == PERM_RO) &&
                   ((req_kind_i == KIND_LOAD) || (req_kind_i == KIND_FETCH))));
      end
      OP_AVAIL: avail_d = avail;
      OP_ALLOC: begin
        if (pres_any || !free_any) err_d = 1'b1;
        else begin
          wr_d        = 1'b1;
          way_d       = free_way;
          n_vld       = 1'b1;
          n_addr      = req_addr_i;
          n_perm      = PERM_INV;
          n_own       = NO_OWNER;
          touch_d     = req_touch_i;
          touch_way_d = free_way;
        end
      end
      OP_FREE: begin
        if (!pres_any) err_d = 1'b1;
        else begin
          wr_d   = 1'b1;
          n_vld  = 1'b0;
          n_perm = PERM_NP;
          n_own  = NO_OWNER;
        end
      end
      OP_PROBE: begin
        if (avail) err_d = 1'b1;
        else begin
          way_d  = victim_way;
          addr_d = ent_addr[flat(req_set, victim_way)];
        end
      end
      OP_LOCK, OP_UNLOCK: begin
        if (!pres_any) err_d = 1'b1;
        else begin
          wr_d  = 1'b1;
          n_own = (req_op_i == OP_LOCK) ? req_ctx_i : NO_OWNER;
        end
      end
      OP_LOCKED: begin
        if (!pres_any) err_d = 1'b1;
        else locked_d = (ent_own[tgt] == req_ctx_i);
      end
      OP_SETPERM: begin
        if (!pres_any || (req_perm_i > PERM_BUSY)) err_d = 1'b1;
        else begin
          wr_d   = 1'b1;
          n_perm = req_perm_i;
        end
      end
      OP_READIDX: begin
        if (req_addr_i >= ADDR_W'(ENTRIES)) err_d = 1'b1;
        else if (ent_vld[ridx] && (ent_perm[ridx] > PERM_INV))
          addr_d = ent_addr[ridx];
      end
      default: err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld  <= '0;
      ent_addr <= '0;
      ent_perm <= '0;
      ent_own  <= {ENTRIES{NO_OWNER}};
    end else if (fire && wr_d) begin
      ent_vld[tgt]  <= n_vld;
      ent_addr[tgt] <= n_addr;
      ent_perm[tgt] <= n_perm;
      ent_own[tgt]  <= n_own;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q      <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_way_o    <= '0;
      rsp_grant_o  <= 1'b0;
      rsp_avail_o  <= 1'b0;
      rsp_locked_o <= 1'b0;
      rsp_addr_o   <= '0;
    end else begin
      ready_q      <= 1'b1;
      rsp_valid_o  <= fire;
      rsp_err_o    <= fire && err_d;
      rsp_hit_o    <= fire && hit_d;
      rsp_way_o    <= fire ? way_d : '0;
      rsp_grant_o  <= fire && grant_d;
      rsp_avail_o  <= fire && avail_d;
      rsp_locked_o <= fire && locked_d;
      rsp_addr_o   <= fire ? addr_d : '0;
    end
  end
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
  parameter int ADDR_W = 32,
  parameter int ASSOC  = 4,
  parameter int CTX_W  = 4,
  localparam int WAY_W = (ASSOC > 1) ? $clog2(ASSOC) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [3:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_kind_i,
  input logic              req_touch_i,
  input logic [CTX_W-1:0]  req_ctx_i,
  input logic [2:0]        req_perm_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              rsp_hit_o,
  input logic [WAY_W-1:0]  rsp_way_o,
  input logic              rsp_grant_o,
  input logic              rsp_avail_o,
  input logic              rsp_locked_o,
  input logic [ADDR_W-1:0] rsp_addr_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  assert_rsp_next_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);

  assert_no_spurious_rsp_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !rsp_valid_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_err_o || rsp_hit_o || rsp_grant_o || rsp_avail_o ||
                       rsp_locked_o || (rsp_addr_o != '0) || (rsp_way_o != '0)));

  assert_err_no_result_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !(rsp_hit_o || rsp_grant_o || rsp_locked_o || (rsp_addr_o != '0)));

  assert_grant_needs_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_grant_o |-> rsp_hit_o);

  assert_avail_never_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && req_op_i == 4'd3) |=> !rsp_err_o);
endmodule

bind tagdir tagdir_chk #(.ADDR_W(ADDR_W), .ASSOC(ASSOC), .CTX_W(CTX_W)) u_chk (.*);

// File: tb/tagdir_tb_top.sv
module tagdir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int ASSOC = 4;
  localparam int SETS = 4;
  localparam int START = 6;
  localparam int IDX_W = 2;
  localparam int CTX_W = 4;
  localparam int ENTRIES = SETS * ASSOC;
  localparam int RW = 1 + 2 + 1 + 1 + 1 + ADDR_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [3:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic req_touch = 1'b0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic [2:0] req_perm = '0;
  logic rsp_valid, rsp_err, rsp_hit, rsp_grant, rsp_avail, rsp_locked;
  logic [1:0] rsp_way;
  logic [ADDR_W-1:0] rsp_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tagdir dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_kind_i(req_kind),
    .req_touch_i(req_touch), .req_ctx_i(req_ctx), .req_perm_i(req_perm),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_hit_o(rsp_hit),
    .rsp_way_o(rsp_way), .rsp_grant_o(rsp_grant), .rsp_avail_o(rsp_avail),
    .rsp_locked_o(rsp_locked), .rsp_addr_o(rsp_addr)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit          m_vld [ENTRIES];
  logic [31:0] m_addr[ENTRIES];
  int          m_perm[ENTRIES];
  int          m_own [ENTRIES];
  int          m_age [ENTRIES];

  logic [RW-1:0] exp_q[$];
  string         tag_q[$];

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic void m_touch(int s, int w);
    int a = m_age[s*ASSOC+w];
    for (int k = 0; k < ASSOC; k++)
      if (m_age[s*ASSOC+k] < a) m_age[s*ASSOC+k]++;
    m_age[s*ASSOC+w] = 0;
  endfunction

  function automatic logic [RW-1:0] model(int op, logic [31:0] addr, int kind,
                                          bit touch, int ctx, int perm);
    int s = int'(addr[START +: IDX_W]);
    int b = s * ASSOC;
    int mw = -1, pw = -1, fw = -1;
    bit hit = 0, grant = 0, avail, locked = 0, err = 0;
    int way = 0;
    logic [31:0] ra = '0;
    for (int w = 0; w < ASSOC; w++) begin
      if (m_vld[b+w] && m_addr[b+w] == addr) begin
        if (mw < 0) mw = w;
        if (m_perm[b+w] != 0 && pw < 0) pw = w;
      end
      if ((!m_vld[b+w] || m_perm[b+w] == 0) && fw < 0) fw = w;
    end
    avail = (mw >= 0) || (fw >= 0);
    case (op)
      0: if (pw >= 0) begin hit = 1; way = pw; m_touch(s, pw); end
      1: if (mw >= 0) begin hit = 1; way = mw; end
      2: if (pw >= 0) begin
           hit = 1; way = pw;
           grant = (m_perm[b+pw] == 3) || (m_perm[b+pw] == 2 && (kind == 0 || kind == 1));
           m_touch(s, pw);
         end
      3: ;
      4: if (pw >= 0 || fw < 0) err = 1;
         else begin
           way = fw; m_vld[b+fw] = 1; m_addr[b+fw] = addr; m_perm[b+fw] = 1;
           m_own[b+fw] = 15;
           if (touch) m_touch(s, fw);
         end
      5: if (pw < 0) err = 1; else begin m_vld[b+pw] = 0; m_perm[b+pw] = 0; end
      6: if (avail) err = 1;
         else for (int w = 0; w < ASSOC; w++)
           if (m_age[b+w] == ASSOC - 1) begin way = w; ra = m_addr[b+w]; end
      7: if (pw < 0) err = 1; else m_own[b+pw] = ctx;
      8: if (pw < 0) err = 1; else m_own[b+pw] = 15;
      9: if (pw < 0) err = 1; else locked = (m_own[b+pw] == ctx);
      10: if (pw < 0 || perm > 4) err = 1; else m_perm[b+pw] = perm;
      11: if (addr >= ENTRIES) err = 1;
          else if (m_vld[addr] && m_perm[addr] > 1) ra = m_addr[addr];
      default: err = 1;
    endcase
    return {hit, 2'(way), grant, (op == 3) ? avail : 1'b0, locked, ra, err};
  endfunction

  task automatic send(int op, logic [31:0] addr, string tag, int kind = 0,
                      bit touch = 0, int ctx = 0, int perm = 0);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 4'(op);
    req_addr  = addr;
    req_kind  = 2'(kind);
    req_touch = touch;
    req_ctx   = 4'(ctx);
    req_perm  = 3'(perm);
    exp_q.push_back(model(op, addr, kind, touch, ctx, perm));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R3";
      2: return "R4";
      3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      7, 8, 9: return "R9";
      10: return "R11";
      11: return "R10";
      default: return "R12";
    endcase
  endfunction

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      logic [RW-1:0] act, ex;
      string t;
      act = {rsp_hit, rsp_way, rsp_grant, rsp_avail, rsp_locked, rsp_addr, rsp_err};
      if (exp_q.size() == 0) begin
        check(0, "R13", $sformatf("response with none pending got=%h exp=none", act));
      end else begin
        ex = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act === ex, t, $sformatf(
          "got hit=%0b way=%0d gr=%0b av=%0b lk=%0b addr=%h err=%0b exp hit=%0b way=%0d gr=%0b av=%0b lk=%0b addr=%h err=%0b",
          act[38], act[37:36], act[35], act[34], act[33], act[32:1], act[0],
          ex[38], ex[37:36], ex[35], ex[34], ex[33], ex[32:1], ex[0]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      m_vld[i] = 0; m_addr[i] = '0; m_perm[i] = 0; m_own[i] = 15; m_age[i] = i % ASSOC;
    end
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0 && rsp_valid === 1'b0, "R1",
          $sformatf("in reset got ready=%0b valid=%0b exp 0 0", req_ready, rsp_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1", $sformatf("after reset got ready=%0b exp 1", req_ready));

    send(0, 32'h000, "R1");
    send(3, 32'h000, "R6");
    send(4, 32'h100, "R7");
    send(4, 32'h200, "R7");
    send(4, 32'h300, "R7");
    send(4, 32'h400, "R7");
    send(4, 32'h140, "R2");
    send(0, 32'h100, "R2");
    send(0, 32'h140, "R2");
    send(0, 32'h500, "R3");
    send(3, 32'h500, "R6");
    send(3, 32'h300, "R6");
    send(4, 32'h500, "R12");
    send(4, 32'h200, "R12");
    send(6, 32'h500, "R8");
    send(0, 32'h400, "R5");
    send(6, 32'h500, "R5");
    send(1, 32'h300, "R5");
    send(6, 32'h500, "R5");
    send(2, 32'h100, "R4", 0);
    send(10, 32'h100, "R11", 0, 0, 0, 2);
    send(2, 32'h100, "R4", 0);
    send(2, 32'h100, "R4", 1);
    send(2, 32'h100, "R4", 2);
    send(10, 32'h200, "R11", 0, 0, 0, 3);
    send(2, 32'h200, "R4", 2);
    send(10, 32'h300, "R11", 0, 0, 0, 4);
    send(2, 32'h300, "R4", 0);
    send(10, 32'h400, "R11", 0, 0, 0, 0);
    send(0, 32'h400, "R3");
    send(1, 32'h400, "R3");
    send(3, 32'h500, "R6");
    send(6, 32'h500, "R12");
    send(4, 32'h500, "R7", 0, 1);
    send(6, 32'h600, "R8");
    send(7, 32'h100, "R9", 0, 0, 3);
    send(9, 32'h100, "R9", 0, 0, 3);
    send(9, 32'h100, "R9", 0, 0, 2);
    send(8, 32'h100, "R9");
    send(9, 32'h100, "R9", 0, 0, 3);
    send(9, 32'h700, "R12", 0, 0, 3);
    send(5, 32'h100, "R7");
    send(9, 32'h100, "R12", 0, 0, 15);
    send(4, 32'h100, "R7");
    send(9, 32'h100, "R7", 0, 0, 15);
    send(11, 32'd0, "R10");
    send(11, 32'd1, "R10");
    send(11, 32'd2, "R10");
    send(11, 32'd4, "R10");
    send(11, 32'd16, "R12");
    send(12, 32'h100, "R12");
    send(10, 32'h100, "R12", 0, 0, 0, 5);
    send(5, 32'h700, "R12");
    idle(2);

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 13;
      logic [31:0] a = (32'($urandom % 6 + 1) << 8) | (32'($urandom % SETS) << START);
      if (op == 11) a = 32'($urandom % 18);
      send(op, a, tag_of(op), $urandom % 3, 1'($urandom % 2), $urandom % 4, $urandom % 6);
      if (i % 97 == 0) idle(1);
    end
    idle(4);
    check(exp_q.size() == 0, "R13",
          $sformatf("pending got=%0d exp=0", exp_q.size()));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule